// File: doc/BRIEF.md
# Flash Program/Erase Unlock Sequencer

This block guards program and erase operations on an on-chip nonvolatile array. Software reaches it through a byte-wide register port that holds a command register, a status register, a page register and a two-byte frequency setting. Program and erase stay impossible until the software writes a fixed handshake of page and key bytes. Once the handshake completes, the block raises a program-enable level and turns erase commands into single-cycle strobes for the array model.

The handshake has four steps in this order:
1. Choose a page by writing the page register.
2. Write the first key byte to the command register.
3. Write the second key byte to the command register.
4. Write the page register again with the same value.

The block also has these guards:
- A sector-protection mask can veto the unlock.
- A global write-protect input blocks program and erase.
- Nothing is issued until both frequency bytes have been written since reset.
- After each erase, a busy window of a fixed, parameterised length holds off further strobes.

The block carries no data stream. Every write takes effect at the clock edge where `wr_en` is sampled high, so there is no valid/ready back-pressure. Reads are combinational from `addr`.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After reset the status code is 000000 and `prog_en`, `erase_pulse`, `mass_pulse` and `busy` are 0. The page and frequency registers read back 00H.
- R2: The register map is: command at address 0, status at address 1, page at address 2, frequency high byte at address 3, frequency low byte at address 4. The status byte is {busy, 0, code[5:0]}.
- R3: The unlock sequence is a page write, then 73H to the command register, then 8CH to the command register, then a page write with the same byte. After each step the status code reads 000000, 000001, 000010 and 000011 (open) in turn.
- R4: If the two page writes carry different bytes, the controller ends the handshake locked (code 000000).
- R5: If the page's sector (page bits [6:4]) has its bit set in `prot_mask`, the controller ends the handshake locked, even when the byte sequence is correct.
- R6: A wrong command byte at any step sends the controller straight to locked, and no progress is kept. A page write during the key steps also sends it to locked.
- R7: While open, a command write other than 95H (page erase) or 63H (mass erase) re-locks the controller. A page write while open also re-locks it.
- R8: While open and permitted, a 95H write gives a one-cycle `erase_pulse` in the cycle after the write. `erase_page` carries page bits [6:0] during the pulse, and the controller stays open.
- R9: While open and permitted, a 63H write gives a one-cycle `mass_pulse` in the cycle after the write.
- R10: Each strobe starts a busy window of BUSY_CYCLES cycles that begins with the strobe. During the window, `prog_en` is 0 and erase commands issue no strobe.
- R11: While `wp` is 1, `prog_en` is 0 and no strobe is issued.
- R12: Until both frequency bytes have been written since reset, `prog_en` is 0 and no strobe is issued.
- R13: Page register bit 7 is an information-area select bit. It reads back with the page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| prot_mask | input | 8 | One protect bit per sector |
| wp | input | 1 | Global write protect |
| prog_en | output | 1 | Byte programming permitted |
| erase_pulse | output | 1 | Page-erase strobe |
| erase_page | output | 7 | Page number for the erase strobe |
| mass_pulse | output | 1 | Mass-erase strobe |
| busy | output | 1 | Erase busy window |

## Verification
The hardest state to reach from the ports is an erase command that arrives while the controller is open but cannot act. Three conditions cause this: a busy window still running, write protect raised after the unlock, or frequency bytes never written after a fresh reset. In each case the controller must stay open yet issue no strobe.

The stimulus builds each case the same way. It first completes the full handshake, then enters the blocking condition, then writes 95H. A behavioural reference model is compared with the outputs on every clock, so wrong-byte, mismatch and protected-sector exits are also checked at every intermediate step.

// File: rtl/flu_pkg.sv
package flu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_PAGE = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRQH = 3'd3;
  localparam logic [ADDR_W-1:0] A_FRQL = 3'd4;

  localparam logic [7:0] KEY_A    = 8'h73;
  localparam logic [7:0] KEY_B    = 8'h8C;
  localparam logic [7:0] OP_PAGE  = 8'h95;
  localparam logic [7:0] OP_MASS  = 8'h63;

  typedef enum logic [2:0] {
    SQ_LOCK, SQ_ARMED, SQ_KEY1, SQ_KEY2, SQ_OPEN
  } seq_t;

  function automatic logic [5:0] seq_code(seq_t s);
    case (s)
      SQ_KEY1: seq_code = 6'd1;
      SQ_KEY2: seq_code = 6'd2;
      SQ_OPEN: seq_code = 6'd3;
      default: seq_code = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/flu_regs.sv
module flu_regs
  import flu_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        stat_byte,
  output logic [7:0]        page_byte,
  output logic              freq_ok,
  output logic [7:0]        rdata
);
  logic [7:0]  page_q;
  logic [15:0] freq_q;
  logic        seen_hi, seen_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      freq_q  <= '0;
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_PAGE: begin
          page_q             <= '0;
          page_q[PAGE_W-1:0] <= wdata[PAGE_W-1:0];
          page_q[7]          <= wdata[7];
        end
        A_FRQH: begin freq_q[15:8] <= wdata; seen_hi <= 1'b1; end
        A_FRQL: begin freq_q[7:0]  <= wdata; seen_lo <= 1'b1; end
        default: ;
      endcase
    end
  end

  assign page_byte = page_q;
  assign freq_ok   = seen_hi & seen_lo;

  always_comb begin
    case (addr)
      A_STAT:  rdata = stat_byte;
      A_PAGE:  rdata = page_q;
      A_FRQH:  rdata = freq_q[15:8];
      A_FRQL:  rdata = freq_q[7:0];
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/flu_seq.sv
module flu_seq
  import flu_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int NSECT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             page_wr,
  input  logic [7:0]       wdata,
  input  logic [NSECT-1:0] prot_mask,
  output seq_t             state,
  output logic             op_page,
  output logic             op_mass
);
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;

  seq_t       st_q, st_d;
  logic [7:0] first_pg_q;
  logic [SECT_W-1:0] sect;
  logic       protected_pg;

  assign sect         = wdata[PAGE_W-1 -: SECT_W];
  assign protected_pg = prot_mask[sect];

  always_comb begin
    st_d    = st_q;
    op_page = 1'b0;
    op_mass = 1'b0;
    if (cmd_wr) begin
      case (st_q)
        SQ_ARMED: st_d = (wdata == KEY_A) ? SQ_KEY1 : SQ_LOCK;
        SQ_KEY1:  st_d = (wdata == KEY_B) ? SQ_KEY2 : SQ_LOCK;
        SQ_OPEN: begin
          if (wdata == OP_PAGE)      op_page = 1'b1;
          else if (wdata == OP_MASS) op_mass = 1'b1;
          else                       st_d = SQ_LOCK;
        end
        default: st_d = SQ_LOCK;
      endcase
    end else if (page_wr) begin
      case (st_q)
        SQ_LOCK, SQ_ARMED: st_d = SQ_ARMED;
        SQ_KEY2: st_d = ((wdata == first_pg_q) && !protected_pg) ? SQ_OPEN : SQ_LOCK;
        default: st_d = SQ_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_LOCK;
      first_pg_q <= '0;
    end else begin
      st_q <= st_d;
      if (page_wr && (st_q == SQ_LOCK || st_q == SQ_ARMED)) first_pg_q <= wdata;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/flu_strobe.sv
module flu_strobe #(
  parameter int PAGE_W      = 7,
  parameter int BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_open,
  input  logic              permit,
  input  logic              op_page,
  input  logic              op_mass,
  input  logic [PAGE_W-1:0] page,
  output logic              prog_en,
  output logic              erase_pulse,
  output logic              mass_pulse,
  output logic [PAGE_W-1:0] erase_page,
  output logic              busy
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

  logic [BW-1:0] cnt_q;
  logic          go;

  assign busy    = (cnt_q != '0);
  assign go      = is_open & permit & ~busy;
  assign prog_en = go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      erase_pulse <= 1'b0;
      mass_pulse  <= 1'b0;
      erase_page  <= '0;
    end else begin
      erase_pulse <= go & op_page;
      mass_pulse  <= go & op_mass;
      if (go & op_page) erase_page <= page;
      if (go & (op_page | op_mass)) cnt_q <= BUSY_LOAD;
      else if (busy)                cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
  import flu_pkg::*;
#(
  parameter int PAGE_W      = 7,
  parameter int NSECT       = 8,
  parameter int BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              wp,
  output logic              prog_en,
  output logic              erase_pulse,
  output logic [PAGE_W-1:0] erase_page,
  output logic              mass_pulse,
  output logic              busy
);
  seq_t       state;
  logic       op_page, op_mass, freq_ok;
  logic [7:0] page_byte, stat_byte;
  logic [5:0] code;

  assign code      = seq_code(state);
  assign stat_byte = {busy, 1'b0, code};

  flu_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat_byte(stat_byte), .page_byte(page_byte), .freq_ok(freq_ok), .rdata(rdata)
  );

  flu_seq #(.PAGE_W(PAGE_W), .NSECT(NSECT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_en && addr == A_CMD), .page_wr(wr_en && addr == A_PAGE),
    .wdata(wdata), .prot_mask(prot_mask),
    .state(state), .op_page(op_page), .op_mass(op_mass)
  );

  flu_strobe #(.PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .is_open(state == SQ_OPEN),
    .permit(~wp & freq_ok), .op_page(op_page), .op_mass(op_mass),
    .page(page_byte[PAGE_W-1:0]), .prog_en(prog_en),
    .erase_pulse(erase_pulse), .mass_pulse(mass_pulse),
    .erase_page(erase_page), .busy(busy)
  );
endmodule

// File: rtl/flu_chk.sv
module flu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp,
  input logic       freq_ok,
  input logic [5:0] code,
  input logic       prog_en,
  input logic       erase_pulse,
  input logic       mass_pulse,
  input logic       busy
);
  AST_STROBE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_pulse || mass_pulse) |-> $past(code) == 6'd3); // R8
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp) |-> !(erase_pulse || mass_pulse)); // R11
  AST_FREQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_pulse || mass_pulse) |-> $past(freq_ok)); // R12
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |=> !erase_pulse); // R8
  AST_MASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mass_pulse |=> !mass_pulse); // R9
  AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_pulse || mass_pulse) |-> busy && !prog_en); // R10
  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 6'd3) |-> !prog_en); // R3
  AST_KEY2_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 6'd2) |-> ($past(code) == 6'd1 || $past(code) == 6'd2)); // R6
endmodule

bind flash_unlock_ctrl flu_chk u_flu_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .freq_ok(freq_ok), .code(code),
  .prog_en(prog_en), .erase_pulse(erase_pulse), .mass_pulse(mass_pulse), .busy(busy)
);

// File: tb/test_flash_unlock_ctrl.sv
`timescale 1ns/1ps
module test_flash_unlock_ctrl;
  localparam int BUSY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] prot_mask = 8'h80;
  logic       wp = 1'b0;
  logic       prog_en, erase_pulse, mass_pulse, busy;
  logic [6:0] erase_page;

  int n_chk = 0;
  int n_bad = 0;

  flash_unlock_ctrl #(.BUSY_CYCLES(BUSY)) i_flash_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .prot_mask(prot_mask), .wp(wp), .prog_en(prog_en),
    .erase_pulse(erase_pulse), .erase_page(erase_page),
    .mass_pulse(mass_pulse), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model: 0 locked,1 armed,2 key1,3 key2,4 open
  int m_st = 0, m_busy = 0;
  bit m_fh = 0, m_fl = 0, m_ep = 0, m_mp = 0;
  logic [7:0] m_pg1 = 0, m_page = 0;
  logic [6:0] m_epage = 0;

  function automatic int m_code();
    case (m_st)
      2: return 1;
      3: return 2;
      4: return 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_fh = 0; m_fl = 0; m_ep = 0; m_mp = 0;
      m_pg1 = 0; m_page = 0; m_epage = 0;
    end else begin
      bit ok;
      int nb;
      ok = (m_st == 4) && !wp && m_fh && m_fl && (m_busy == 0);
      nb = (m_busy > 0) ? m_busy - 1 : 0;
      m_ep = 0; m_mp = 0;
      if (wr_en) begin
        case (addr)
          3'd0: begin
            if (m_st == 1) m_st = (wdata == 8'h73) ? 2 : 0;
            else if (m_st == 2) m_st = (wdata == 8'h8C) ? 3 : 0;
            else if (m_st == 4) begin
              if (wdata == 8'h95) begin
                if (ok) begin m_ep = 1; m_epage = m_page[6:0]; nb = BUSY; end
              end else if (wdata == 8'h63) begin
                if (ok) begin m_mp = 1; nb = BUSY; end
              end else m_st = 0;
            end else m_st = 0;
          end
          3'd2: begin
            if (m_st <= 1) begin m_pg1 = wdata; m_st = 1; end
            else if (m_st == 3) m_st = (wdata == m_pg1 && !prot_mask[wdata[6:4]]) ? 4 : 0;
            else m_st = 0;
            m_page = wdata;
          end
          3'd3: m_fh = 1;
          3'd4: m_fl = 1;
          default: ;
        endcase
      end
      m_busy = nb;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit pe;
      pe = (m_st == 4) && !wp && m_fh && m_fl && (m_busy == 0);
      check("R10 model prog_en", int'(prog_en), int'(pe));
      check("R8 model erase_pulse", int'(erase_pulse), int'(m_ep));
      check("R9 model mass_pulse", int'(mass_pulse), int'(m_mp));
      check("R10 model busy", int'(busy), int'(m_busy != 0));
      if (m_ep) check("R8 model erase_page", int'(erase_page), int'(m_epage));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 3'd1;
  endtask

  task automatic stat_is(input string req, input int code);
    logic [7:0] s;
    rd(3'd1, s);
    check(req, int'(s[5:0]), code);
  endtask

  task automatic unlock(input logic [7:0] pg);
    wr(3'd2, pg); wr(3'd0, 8'h73); wr(3'd0, 8'h8C); wr(3'd2, pg);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    stat_is("R1 status after reset", 0);
    check("R1 prog_en", int'(prog_en), 0);
    check("R1 busy", int'(busy), 0);
    rd(3'd2, v); check("R1 page reset", int'(v), 0);
    rd(3'd3, v); check("R1 freq hi reset", int'(v), 0);

    // R2 register map
    wr(3'd3, 8'h12); wr(3'd4, 8'h34);
    rd(3'd3, v); check("R2 freq hi readback", int'(v), 8'h12);
    rd(3'd4, v); check("R2 freq lo readback", int'(v), 8'h34);

    // R3 sequence with status after each step
    wr(3'd2, 8'h21); stat_is("R3 after page write", 0);
    wr(3'd0, 8'h73); stat_is("R3 after key 73", 1);
    wr(3'd0, 8'h8C); stat_is("R3 after key 8C", 2);
    wr(3'd2, 8'h21); stat_is("R3 open", 3);
    check("R3 prog_en open", int'(prog_en), 1);

    // R8 page erase strobe and R10 busy window
    wr(3'd0, 8'h95);
    check("R8 erase_pulse", int'(erase_pulse), 1);
    check("R8 erase_page", int'(erase_page), 8'h21);
    check("R10 busy after strobe", int'(busy), 1);
    stat_is("R8 stays open", 3);
    @(negedge clk);
    check("R8 pulse one cycle", int'(erase_pulse), 0);
    wr(3'd0, 8'h95);
    check("R10 no strobe while busy", int'(erase_pulse), 0);
    repeat (BUSY) @(negedge clk);
    check("R10 busy cleared", int'(busy), 0);

    // R9 mass erase
    wr(3'd0, 8'h63);
    check("R9 mass_pulse", int'(mass_pulse), 1);
    check("R9 no page pulse", int'(erase_pulse), 0);
    repeat (BUSY + 1) @(negedge clk);

    // R7 relock on other byte
    wr(3'd0, 8'h00); stat_is("R7 relock on 00", 0);
    check("R7 prog_en low", int'(prog_en), 0);
    unlock(8'h10); wr(3'd2, 8'h10); stat_is("R7 relock on page write", 0);

    // R4 mismatch
    wr(3'd2, 8'h21); wr(3'd0, 8'h73); wr(3'd0, 8'h8C); wr(3'd2, 8'h22);
    stat_is("R4 page mismatch locked", 0);

    // R5 protected sector 7
    unlock(8'h75); stat_is("R5 protected locked", 0);
    check("R5 prog_en", int'(prog_en), 0);

    // R6 wrong bytes
    wr(3'd2, 8'h05); wr(3'd0, 8'h73); wr(3'd0, 8'h73); stat_is("R6 repeat 73", 0);
    wr(3'd0, 8'h8C); wr(3'd2, 8'h05); stat_is("R6 no progress kept", 0);
    wr(3'd2, 8'h05); wr(3'd0, 8'h8C); stat_is("R6 8C first", 0);
    wr(3'd2, 8'h05); wr(3'd0, 8'h73); wr(3'd2, 8'h05); stat_is("R6 page during keys", 0);

    // R11 write protect
    unlock(8'h33); stat_is("R11 open", 3);
    @(negedge clk); wp = 1'b1; #1;
    check("R11 prog_en under wp", int'(prog_en), 0);
    wr(3'd0, 8'h95);
    check("R11 no erase under wp", int'(erase_pulse), 0);
    wr(3'd0, 8'h63);
    check("R11 no mass under wp", int'(mass_pulse), 0);
    wp = 1'b0;
    #1 check("R11 prog_en back", int'(prog_en), 1);

    // R13 info bit readback
    wr(3'd2, 8'hA4);
    rd(3'd2, v); check("R13 info bit readback", int'(v), 8'hA4);

    // R12 frequency not written
    do_reset();
    unlock(8'h21); stat_is("R12 open without freq", 3);
    check("R12 prog_en gated", int'(prog_en), 0);
    wr(3'd0, 8'h95);
    check("R12 no strobe", int'(erase_pulse), 0);
    wr(3'd3, 8'h01);
    check("R12 one byte not enough", int'(prog_en), 0);
    wr(3'd4, 8'h02);
    check("R12 both bytes", int'(prog_en), 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule